// File: doc/BRIEF.md
# MFM Write Precompensation Shifter

This block sits between a floppy disk controller and the drive's write-data line during double-density (MFM) recording. The controller marks each outgoing write pulse as one to be sent early, on time or late. The block then moves that pulse by one step of a fast clock in the chosen direction. A shift register clocked by the fast clock holds delayed copies of the write pulse. A multiplexer chooses which copy drives the output. Because a pulse can only be delayed and never advanced, the on-time output is itself delayed by one step. An early pulse comes from the tap ahead of it and a late pulse from the tap behind it.

The direction is taken from the two steering inputs and the density input at the moment a new pulse arrives. It stays fixed until that pulse has left the shift register, so every pulse leaves the block with the width it came in with. In single-density (FM) mode the steering inputs are ignored and every pulse takes the on-time tap. The output timing therefore does not depend on the density setting, apart from the shift itself.

Top module: `precomp_shifter`

## Requirements
- R1: While `rstN` is low, `wdOut` is low, even if `wdIn` pulses. After reset is released, `wdOut` stays low until a pulse has passed through the shift register.
- R2: In MFM mode (`mfmSel`=1) with `earlyIn`=1 and `lateIn`=0 at capture, if `wdIn` is first sampled high at clock edge k, then `wdOut` first goes high after edge k+1.
- R3: In MFM mode with `earlyIn`=0 and `lateIn`=0 at capture, `wdOut` first goes high after edge k+1+STEP. With the default STEP=1 this is edge k+2.
- R4: In MFM mode with `earlyIn`=0 and `lateIn`=1 at capture, `wdOut` first goes high after edge k+1+2·STEP. With the default this is edge k+3.
- R5: In MFM mode with both `earlyIn` and `lateIn` high at capture, the pulse takes the on-time delay of R3.
- R6: In FM mode (`mfmSel`=0), the pulse takes the on-time delay of R3 whatever `earlyIn` and `lateIn` are.
- R7: A pulse sampled high on W consecutive edges produces an output pulse exactly W cycles wide, whichever delay was chosen.
- R8: Capture takes place only at the edge where a new pulse is first sampled high. Changes to `earlyIn`, `lateIn` or `mfmSel` after that edge do not move the pulse already in flight.
- R9: If `wdIn` rises while an earlier pulse still occupies any stage of the shift register, the new pulse reuses the earlier pulse's selection and the steering inputs at that edge are ignored.
- R10: If `wdIn` has been low on more than 2·STEP+1 consecutive edges, `wdOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; one period is one shift step |
| rstN | input | 1 | Asynchronous active-low reset |
| wdIn | input | 1 | Raw write-data pulse from the controller |
| earlyIn | input | 1 | Controller request to send the current pulse early |
| lateIn | input | 1 | Controller request to send the current pulse late |
| mfmSel | input | 1 | 1 = double density (MFM, shift active), 0 = single density (FM, always on time) |
| wdOut | output | 1 | Write-data pulse after precompensation |

## Verification
Two functions of the block can fall in the same cycle: capturing a new selection when a fresh pulse rises, and holding the earlier selection while a previous pulse is still in the shift register. The bench provokes this case in two ways. It raises a second pulse with an early request just after a late pulse has entered the register, and it flips every steering input one cycle after a capture. The bench then follows the output cycle by cycle. The second pulse must appear at the late position, separated from the first by a low cycle. If a wrong capture takes place, the second pulse instead merges into the first one's tail, or the first pulse moves.

// File: rtl/precomp_pkg.sv
package precomp_pkg;

  // Tap chosen for the pulse currently travelling through the shift register.
  typedef enum logic [1:0] {
    TAP_EARLY = 2'd0,
    TAP_NOM   = 2'd1,
    TAP_LATE  = 2'd2
  } tap_e;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    tap_e tapSel;
  } ctrl_t;

  // Maps the steering inputs to a tap. FM mode and the "both high" case give the on-time tap.
  function automatic tap_e decodeTap(input logic mfm, input logic early, input logic late);
    tap_e t;
    if (!mfm) begin
      t = TAP_NOM;
    end else begin
      case ({early, late})
        2'b10:   t = TAP_EARLY;
        2'b01:   t = TAP_LATE;
        default: t = TAP_NOM;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/precomp_ctrl.sv
module precomp_ctrl
  import precomp_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  wdIn,
  input  logic  earlyIn,
  input  logic  lateIn,
  input  logic  mfmSel,
  input  logic  chainBusy,
  output ctrl_t ctrl
);

  // A new pulse may set the tap only when the shift register is empty.
  logic captureNow;
  assign captureNow = wdIn && !chainBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl.tapSel <= TAP_NOM;
    end else if (captureNow) begin
      ctrl.tapSel <= decodeTap(mfmSel, earlyIn, lateIn);
    end
  end

  // The selection never moves while any stage still carries a pulse.
  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    chainBusy |=> $stable(ctrl.tapSel));

  // A capture in FM mode always yields the on-time tap.
  assert_fm_nominal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wdIn && !chainBusy && !mfmSel) |=> (ctrl.tapSel == TAP_NOM));

  // Both requests high in MFM mode resolve to the on-time tap.
  assert_both_nominal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wdIn && !chainBusy && mfmSel && earlyIn && lateIn) |=> (ctrl.tapSel == TAP_NOM));

endmodule

// File: rtl/precomp_datapath.sv
module precomp_datapath
  import precomp_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  wdIn,
  input  ctrl_t ctrl,
  output logic  chainBusy,
  output logic  wdOut
);

  localparam int CHAIN_LEN = 2 * STEP + 1;
  localparam int IDX_NOM   = STEP;
  localparam int IDX_LATE  = 2 * STEP;

  logic [CHAIN_LEN-1:0] chain;
  logic                 tapBit;

  // Stage 0 takes the input directly; each later stage takes the stage before it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= 1'b0;
    else       chain[0] <= wdIn;
  end

  for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[g] <= 1'b0;
      else       chain[g] <= chain[g-1];
    end
  end

  assign chainBusy = |chain;

  always_comb begin
    case (ctrl.tapSel)
      TAP_EARLY: tapBit = chain[0];
      TAP_LATE:  tapBit = chain[IDX_LATE];
      default:   tapBit = chain[IDX_NOM];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdOut <= 1'b0;
    else       wdOut <= tapBit;
  end

  // The control only ever hands over one of the three defined taps.
  assert_valid_tap_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.tapSel inside {TAP_EARLY, TAP_NOM, TAP_LATE});

endmodule

// File: rtl/precomp_shifter.sv
module precomp_shifter
  import precomp_pkg::*;
#(
  parameter int STEP = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wdIn,
  input  logic earlyIn,
  input  logic lateIn,
  input  logic mfmSel,
  output logic wdOut
);

  localparam int CHAIN_LEN = 2 * STEP + 1;
  localparam int IDLE_MAX  = CHAIN_LEN + 2;
  localparam int IDLE_W    = $clog2(IDLE_MAX + 1);

  ctrl_t ctrl;
  logic  chainBusy;

  precomp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wdIn      (wdIn),
    .earlyIn   (earlyIn),
    .lateIn    (lateIn),
    .mfmSel    (mfmSel),
    .chainBusy (chainBusy),
    .ctrl      (ctrl)
  );

  precomp_datapath #(.STEP(STEP)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wdIn      (wdIn),
    .ctrl      (ctrl),
    .chainBusy (chainBusy),
    .wdOut     (wdOut)
  );

  // Checker counter: the number of edges since wdIn was last sampled high.
  logic [IDLE_W-1:0] idleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 idleCnt <= '0;
    else if (wdIn)                             idleCnt <= '0;
    else if (idleCnt != IDLE_W'(IDLE_MAX))     idleCnt <= idleCnt + 1'b1;
  end

  assert_quiet_after_drain_R10: assert property (@(posedge clk) disable iff (!rstN)
    (idleCnt > IDLE_W'(CHAIN_LEN)) |-> !wdOut);

  // A rising output must come from a pulse that entered the register earlier.
  assert_no_spurious_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdOut) |-> (idleCnt <= IDLE_W'(CHAIN_LEN)));

endmodule

// File: tb/tb_precomp_shifter.sv
`timescale 1ns/1ps
module tb_precomp_shifter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wdIn = 1'b0;
  logic earlyIn = 1'b0;
  logic lateIn = 1'b0;
  logic mfmSel = 1'b0;
  logic wdOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  precomp_shifter dut (
    .clk(clk), .rstN(rstN), .wdIn(wdIn), .earlyIn(earlyIn),
    .lateIn(lateIn), .mfmSel(mfmSel), .wdOut(wdOut)
  );

  typedef struct packed {
    logic       mfm;
    logic       early;
    logic       late;
    logic [3:0] width;
    logic [3:0] expFirst;
    logic [3:0] req;
  } vec_t;

  // expFirst counts negedge samples after the one that raises wdIn: early 2, on time 3, late 4.
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b0, 4'd2, 4'd2, 4'd2},  // R2 early
    '{1'b1, 1'b0, 1'b0, 4'd2, 4'd3, 4'd3},  // R3 on time
    '{1'b1, 1'b0, 1'b1, 4'd2, 4'd4, 4'd4},  // R4 late
    '{1'b1, 1'b1, 1'b1, 4'd2, 4'd3, 4'd5},  // R5 both high
    '{1'b0, 1'b1, 1'b0, 4'd3, 4'd3, 4'd6},  // R6 FM ignores early
    '{1'b0, 1'b0, 1'b1, 4'd1, 4'd3, 4'd6},  // R6 FM ignores late
    '{1'b1, 1'b1, 1'b0, 4'd5, 4'd2, 4'd7},  // R7 wide early pulse
    '{1'b1, 1'b0, 1'b1, 4'd1, 4'd4, 4'd7},  // R7 narrow late pulse
    '{1'b0, 1'b1, 1'b1, 4'd4, 4'd3, 4'd6},  // R6 FM with both high
    '{1'b1, 1'b0, 1'b0, 4'd6, 4'd3, 4'd7}   // R7 wide on-time pulse
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sends one pulse and watches wdOut for 16 cycles. With flip set, all steering inputs toggle one cycle after capture.
  task automatic runPulse(input logic mfm, input logic e, input logic l, input int w,
                          input bit flip, output int firstHi, output int hiCnt);
    firstHi = 0;
    hiCnt = 0;
    @(negedge clk);
    mfmSel = mfm; earlyIn = e; lateIn = l; wdIn = 1'b1;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      if (wdOut) begin
        hiCnt++;
        if (firstHi == 0) firstHi = j;
      end
      if (j == w) wdIn = 1'b0;
      if (flip && j == 1) begin
        mfmSel = ~mfmSel; earlyIn = ~earlyIn; lateIn = ~lateIn;
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int fh;
    int hc;
    // R1: a pulse during reset produces no output.
    mfmSel = 1'b1; earlyIn = 1'b1;
    repeat (2) @(negedge clk);
    wdIn = 1'b1;
    repeat (3) @(negedge clk);
    check(wdOut == 1'b0, "R1 in reset", wdOut, 0);
    wdIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    check(wdOut == 1'b0, "R1 after reset", wdOut, 0);

    // Vector table walk covering R2, R3, R4, R5, R6 and R7.
    for (int v = 0; v < NVEC; v++) begin
      runPulse(VECS[v].mfm, VECS[v].early, VECS[v].late, int'(VECS[v].width), 1'b0, fh, hc);
      check(fh == int'(VECS[v].expFirst), $sformatf("R%0d delay vec%0d", VECS[v].req, v),
            fh, int'(VECS[v].expFirst));
      check(hc == int'(VECS[v].width), $sformatf("R7 width vec%0d", v), hc, int'(VECS[v].width));
    end

    // R8: early captured, then inputs flip to late/FM one cycle later; the pulse stays early.
    runPulse(1'b1, 1'b1, 1'b0, 3, 1'b1, fh, hc);
    check(fh == 2, "R8 delay kept", fh, 2);
    check(hc == 3, "R8 width kept", hc, 3);

    // R9: a late pulse of 2 cycles, then a 1-cycle pulse with an early request while the register is still busy.
    @(negedge clk);
    mfmSel = 1'b1; earlyIn = 1'b0; lateIn = 1'b1; wdIn = 1'b1;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j == 2) wdIn = 1'b0;
      if (j == 3) begin wdIn = 1'b1; earlyIn = 1'b1; lateIn = 1'b0; end
      if (j == 4) wdIn = 1'b0;
      if (j == 4) check(wdOut == 1'b1, "R9 first pulse start", wdOut, 1);
      if (j == 5) check(wdOut == 1'b1, "R9 first pulse end", wdOut, 1);
      if (j == 6) check(wdOut == 1'b0, "R9 gap kept", wdOut, 0);
      if (j == 7) check(wdOut == 1'b1, "R9 second pulse late", wdOut, 1);
      if (j == 8) check(wdOut == 1'b0, "R9 second pulse width", wdOut, 0);
    end

    // R10: the output is quiet once the register has drained.
    earlyIn = 1'b0;
    repeat (5) @(negedge clk);
    check(wdOut == 1'b0, "R10 idle", wdOut, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule